// File: doc/BRIEF.md
# Multiply/Divide Extension Unit

This block executes the extended arithmetic operations of an 8-bit accumulator processor. It holds one extra 8-bit register, the high-result byte (here called MHI), that widens the accumulator D to 16 bits for products and dividends. The surrounding core decodes the prefix byte and presents the second opcode byte, the present accumulator value, the byte read from memory at the X pointer and the immediate byte. The unit works out in the same cycle the new value of D with a write enable, and the new value of MHI with a write enable. MHI itself is updated at the next rising clock edge.

The operations are nibble swap, clear/load/get of MHI, multiply, 16-by-8 divide and modulo. The three arithmetic kinds each come in a memory-operand form and an immediate form. Opcode bit 3 chooses the form: set selects the immediate byte, clear selects the memory byte. Every operation finishes in a single clock cycle. The multiplier and the divider are unrolled combinational arrays.

Top module: `xmd_unit`

## Requirements
- R1: With op_valid high and op_code 7Bh, d_we is 1 and d_next is d_in with its upper and lower 4-bit halves exchanged. mhi_we is 0.
- R2: With op_valid high and op_code A0h, mhi_we is 1 and mhi_next is 00h. mhi_q reads 00h after the next rising edge. d_we is 0.
- R3: With op_valid high and op_code A1h, mhi_we is 1 and mhi_next equals d_in. mhi_q holds that value after the next rising edge. d_we is 0.
- R4: With op_valid high and op_code 90h, d_we is 1 and d_next equals the current mhi_q. mhi_we is 0.
- R5: Op_code F4h multiplies d_in by mem_opnd, and FCh multiplies d_in by imm_opnd. Both set d_we and mhi_we to 1. d_next is the low byte of the 16-bit product, and mhi_next, which reaches mhi_q at the next edge, is the high byte.
- R6: Op_code F5h divides by mem_opnd and FDh divides by imm_opnd. The dividend is {mhi_q, d_in}, and the divisor must be non-zero. d_next receives the quotient bits 7:0 and mhi_next the quotient bits 15:8. Both write enables are 1.
- R7: Op_code F3h (mem_opnd) and FBh (imm_opnd) write the remainder of {mhi_q, d_in} divided by a non-zero divisor to d_next, with d_we equal to 1. mhi_we is 0 and mhi_q does not change.
- R8: With a zero divisor, F5h and FDh give quotient FFFFh (d_next FFh, mhi_next FFh, both enables 1). F3h and FBh give d_next equal to d_in with d_we 1, and leave MHI unchanged.
- R9: With op_valid high and any op_code not listed in R1 to R8, bad_op is 1 for that cycle, both write enables are 0 and mhi_q keeps its value. When d_we is 0, d_next equals d_in.
- R10: With op_valid low, bad_op, d_we and mhi_we are 0 and mhi_q holds. While rst_n is low, mhi_q is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An extended operation is presented this cycle |
| op_code | input | 8 | Second opcode byte after the prefix |
| d_in | input | 8 | Present accumulator value |
| mem_opnd | input | 8 | Byte read from memory at the X pointer |
| imm_opnd | input | 8 | Immediate byte of the instruction |
| d_next | output | 8 | New accumulator value |
| d_we | output | 1 | Accumulator write enable |
| mhi_next | output | 8 | New high-result byte |
| mhi_we | output | 1 | High-result byte write enable |
| mhi_q | output | 8 | Current high-result byte |
| bad_op | output | 1 | Unrecognised opcode presented this cycle |

## Verification
Several functions share one cycle here. A divide reads the old MHI as the dividend's upper byte and produces the new MHI at the same time. An operation issued right after it must see the value just written, whether the previous operation was a load, a clear or a multiply. The bench provokes both cases with gap-free operation streams in which every opcode kind follows every other, with zero divisors and illegal codes mixed in. A behavioural model written with integer division and multiplication predicts d_next, both enables, bad_op and mhi_q, and the bench compares them on every clock.

// File: rtl/xmd_pkg.sv
package xmd_pkg;

  localparam int XMD_DW  = 8;
  localparam int XMD_OPW = 8;

  typedef enum logic [2:0] {
    XK_NONE,
    XK_SWAP,
    XK_CMHI,
    XK_LMHI,
    XK_GMHI,
    XK_MUL,
    XK_DIV,
    XK_MOD
  } xmd_kind_e;

  localparam logic [XMD_OPW-1:0] OPC_SWAP = 8'h7B;
  localparam logic [XMD_OPW-1:0] OPC_CMHI = 8'hA0;
  localparam logic [XMD_OPW-1:0] OPC_LMHI = 8'hA1;
  localparam logic [XMD_OPW-1:0] OPC_GMHI = 8'h90;
  localparam logic [XMD_OPW-1:0] OPC_MULM = 8'hF4;
  localparam logic [XMD_OPW-1:0] OPC_MULI = 8'hFC;
  localparam logic [XMD_OPW-1:0] OPC_DIVM = 8'hF5;
  localparam logic [XMD_OPW-1:0] OPC_DIVI = 8'hFD;
  localparam logic [XMD_OPW-1:0] OPC_MODM = 8'hF3;
  localparam logic [XMD_OPW-1:0] OPC_MODI = 8'hFB;

  // bit of the opcode that picks the immediate byte over the memory byte
  localparam int IMM_SEL_BIT = 3;

  typedef logic [XMD_DW-1:0] xmd_data_t;

  // exchange upper and lower halves of a byte
  function automatic xmd_data_t f_half_swap(input xmd_data_t v);
    return {v[XMD_DW/2-1:0], v[XMD_DW-1:XMD_DW/2]};
  endfunction

  // quotient forced on a zero divisor
  function automatic logic [2*XMD_DW-1:0] f_zero_div_quo();
    return '1;
  endfunction

  // choose the operand byte according to the opcode
  function automatic xmd_data_t f_pick_opnd(input logic [XMD_OPW-1:0] code,
                                            input xmd_data_t mem_b,
                                            input xmd_data_t imm_b);
    return code[IMM_SEL_BIT] ? imm_b : mem_b;
  endfunction

endpackage

// File: rtl/xmd_decode.sv
module xmd_decode
  import xmd_pkg::*;
(
  input  logic               op_valid,
  input  logic [XMD_OPW-1:0] op_code,
  output xmd_kind_e          kind,
  output logic               unknown
);

  xmd_kind_e raw_kind;

  always_comb begin
    unique case (op_code)
      OPC_SWAP:           raw_kind = XK_SWAP;
      OPC_CMHI:           raw_kind = XK_CMHI;
      OPC_LMHI:           raw_kind = XK_LMHI;
      OPC_GMHI:           raw_kind = XK_GMHI;
      OPC_MULM, OPC_MULI: raw_kind = XK_MUL;
      OPC_DIVM, OPC_DIVI: raw_kind = XK_DIV;
      OPC_MODM, OPC_MODI: raw_kind = XK_MOD;
      default:            raw_kind = XK_NONE;
    endcase
  end

  assign kind    = op_valid ? raw_kind : XK_NONE;
  assign unknown = op_valid && (raw_kind == XK_NONE);

endmodule

// File: rtl/xmd_mult.sv
module xmd_mult #(
  parameter int DW        = xmd_pkg::XMD_DW,
  parameter bit USE_ARRAY = 1'b1
) (
  input  logic [DW-1:0]   mcand,
  input  logic [DW-1:0]   mplier,
  output logic [2*DW-1:0] product
);

  localparam int PW = 2 * DW;

  generate
    if (USE_ARRAY) begin : g_array
      logic [PW-1:0] acc [0:DW];
      assign acc[0] = '0;
      for (genvar i = 0; i < DW; i++) begin : g_row
        logic [PW-1:0] part;
        assign part       = mplier[i] ? ({{DW{1'b0}}, mcand} << i) : '0;
        assign acc[i + 1] = acc[i] + part;
      end
      assign product = acc[DW];
    end else begin : g_native
      assign product = {{DW{1'b0}}, mcand} * {{DW{1'b0}}, mplier};
    end
  endgenerate

endmodule

// File: rtl/xmd_div.sv
module xmd_div #(
  parameter int DW = xmd_pkg::XMD_DW
) (
  input  logic [2*DW-1:0] dividend,
  input  logic [DW-1:0]   divisor,
  output logic [2*DW-1:0] quotient,
  output logic [DW-1:0]   remainder,
  output logic            div_zero
);

  localparam int NW = 2 * DW;

  logic [DW-1:0] part [0:NW];
  assign part[0] = '0;

  generate
    for (genvar i = 0; i < NW; i++) begin : g_stage
      logic [DW:0]   shifted;
      logic          fits;
      logic [DW-1:0] diff;
      assign shifted = {part[i], dividend[NW-1-i]};
      assign fits    = shifted >= {1'b0, divisor};
      assign diff    = shifted[DW-1:0] - divisor;
      assign part[i + 1]          = fits ? diff : shifted[DW-1:0];
      assign quotient[NW-1-i]     = fits;
    end
  endgenerate

  assign remainder = part[NW];
  assign div_zero  = (divisor == '0);

endmodule

// File: rtl/xmd_unit.sv
module xmd_unit
  import xmd_pkg::*;
#(
  parameter bit MUL_ARRAY = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [XMD_OPW-1:0] op_code,
  input  logic [XMD_DW-1:0]  d_in,
  input  logic [XMD_DW-1:0]  mem_opnd,
  input  logic [XMD_DW-1:0]  imm_opnd,
  output logic [XMD_DW-1:0]  d_next,
  output logic               d_we,
  output logic [XMD_DW-1:0]  mhi_next,
  output logic               mhi_we,
  output logic [XMD_DW-1:0]  mhi_q,
  output logic               bad_op
);

  localparam int DW = XMD_DW;
  localparam int WW = 2 * DW;

  xmd_kind_e     kind;
  logic [DW-1:0] opnd_sel;
  logic [WW-1:0] prod_w;
  logic [WW-1:0] quo_w;
  logic [DW-1:0] rem_w;
  logic          zero_den;
  logic [WW-1:0] quo_fix;

  xmd_decode u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .kind     (kind),
    .unknown  (bad_op)
  );

  assign opnd_sel = f_pick_opnd(op_code, mem_opnd, imm_opnd);

  xmd_mult #(.DW(DW), .USE_ARRAY(MUL_ARRAY)) u_mul (
    .mcand   (d_in),
    .mplier  (opnd_sel),
    .product (prod_w)
  );

  xmd_div #(.DW(DW)) u_div (
    .dividend  ({mhi_q, d_in}),
    .divisor   (opnd_sel),
    .quotient  (quo_w),
    .remainder (rem_w),
    .div_zero  (zero_den)
  );

  assign quo_fix = zero_den ? f_zero_div_quo() : quo_w;

  always_comb begin
    d_next   = d_in;
    d_we     = 1'b0;
    mhi_next = mhi_q;
    mhi_we   = 1'b0;
    unique case (kind)
      XK_SWAP: begin
        d_we   = 1'b1;
        d_next = f_half_swap(d_in);
      end
      XK_CMHI: begin
        mhi_we   = 1'b1;
        mhi_next = '0;
      end
      XK_LMHI: begin
        mhi_we   = 1'b1;
        mhi_next = d_in;
      end
      XK_GMHI: begin
        d_we   = 1'b1;
        d_next = mhi_q;
      end
      XK_MUL: begin
        d_we     = 1'b1;
        d_next   = prod_w[DW-1:0];
        mhi_we   = 1'b1;
        mhi_next = prod_w[WW-1:DW];
      end
      XK_DIV: begin
        d_we     = 1'b1;
        d_next   = quo_fix[DW-1:0];
        mhi_we   = 1'b1;
        mhi_next = quo_fix[WW-1:DW];
      end
      XK_MOD: begin
        d_we   = 1'b1;
        d_next = zero_den ? d_in : rem_w;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mhi_q <= '0;
    else if (mhi_we) mhi_q <= mhi_next;
  end

endmodule

// File: rtl/xmd_unit_chk.sv
module xmd_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [7:0] op_code,
  input logic [7:0] d_in,
  input logic [7:0] mem_opnd,
  input logic [7:0] imm_opnd,
  input logic [7:0] d_next,
  input logic       d_we,
  input logic [7:0] mhi_next,
  input logic       mhi_we,
  input logic [7:0] mhi_q,
  input logic       bad_op
);

  logic [7:0]  den;
  logic [15:0] num;
  logic [15:0] quo;
  logic [23:0] back;
  logic [15:0] prod;
  logic        is_mul, is_div, is_mod, known;

  assign den    = op_code[3] ? imm_opnd : mem_opnd;
  assign num    = {mhi_q, d_in};
  assign quo    = {mhi_next, d_next};
  assign back   = {8'h00, quo} * {16'h0000, den};
  assign prod   = 16'(d_in * den);
  assign is_mul = (op_code == 8'hF4) || (op_code == 8'hFC);
  assign is_div = (op_code == 8'hF5) || (op_code == 8'hFD);
  assign is_mod = (op_code == 8'hF3) || (op_code == 8'hFB);
  assign known  = is_mul || is_div || is_mod || (op_code == 8'h7B) ||
                  (op_code == 8'hA0) || (op_code == 8'hA1) || (op_code == 8'h90);

  p_swap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 8'h7B |-> d_we && !mhi_we && d_next == {d_in[3:0], d_in[7:4]});

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 8'hA0 |=> mhi_q == 8'h00);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 8'hA1 |=> mhi_q == $past(d_in));

  p_get_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 8'h90 |-> d_we && d_next == mhi_q);

  p_mul_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_mul |-> d_we && d_next == prod[7:0]);

  p_mul_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_mul |=> mhi_q == $past(prod[15:8]));

  p_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_div && den != 8'h00 |->
      d_we && mhi_we && back <= {8'h00, num} && ({8'h00, num} - back) < {16'h0000, den});

  p_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_mod && den != 8'h00 |-> d_we && !mhi_we && d_next < den);

  p_mod_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_mod |=> $stable(mhi_q));

  p_divzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_div && den == 8'h00 |-> d_next == 8'hFF && mhi_next == 8'hFF);

  p_modzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_mod && den == 8'h00 |-> d_we && d_next == d_in);

  p_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !known |-> bad_op && !d_we && !mhi_we && d_next == d_in);

  p_bad_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !known |=> $stable(mhi_q));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !bad_op && !d_we && !mhi_we);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(mhi_q));

  p_reset_r10: assert property (@(posedge clk) !rst_n |-> mhi_q == 8'h00);

endmodule

bind xmd_unit xmd_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .d_in     (d_in),
  .mem_opnd (mem_opnd),
  .imm_opnd (imm_opnd),
  .d_next   (d_next),
  .d_we     (d_we),
  .mhi_next (mhi_next),
  .mhi_we   (mhi_we),
  .mhi_q    (mhi_q),
  .bad_op   (bad_op)
);

// File: tb/xmd_unit_tb_top.sv
module xmd_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [7:0] op_code, d_in, mem_opnd, imm_opnd;
  logic [7:0] d_next, mhi_next, mhi_q;
  logic       d_we, mhi_we, bad_op;

  int n_chk  = 0;
  int n_fail = 0;
  int m_mhi  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  xmd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .d_in(d_in), .mem_opnd(mem_opnd), .imm_opnd(imm_opnd),
    .d_next(d_next), .d_we(d_we), .mhi_next(mhi_next), .mhi_we(mhi_we),
    .mhi_q(mhi_q), .bad_op(bad_op)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input bit v, input int code, input int opnd);
    if (!v) return "R10";
    case (code)
      'h7B: return "R1";
      'hA0: return "R2";
      'hA1: return "R3";
      'h90: return "R4";
      'hF4, 'hFC: return "R5";
      'hF5, 'hFD: return (opnd == 0) ? "R8" : "R6";
      'hF3, 'hFB: return (opnd == 0) ? "R8" : "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic run_op(input bit v, input int code, input int d, input int mem, input int imm);
    int o, e_d, e_dwe, e_m, e_mwe, e_bad, num, q, p;
    string t;
    @(negedge clk);
    op_valid = v; op_code = 8'(code); d_in = 8'(d); mem_opnd = 8'(mem); imm_opnd = 8'(imm);
    o = ((code & 8) != 0) ? imm : mem;
    num = m_mhi * 256 + d;
    e_d = d; e_dwe = 0; e_m = m_mhi; e_mwe = 0; e_bad = 0;
    if (!v) begin
      // nothing happens
    end else begin
      case (code)
        'h7B: begin e_dwe = 1; e_d = ((d % 16) * 16) + (d / 16); end
        'hA0: begin e_mwe = 1; e_m = 0; end
        'hA1: begin e_mwe = 1; e_m = d; end
        'h90: begin e_dwe = 1; e_d = m_mhi; end
        'hF4, 'hFC: begin p = d * o; e_dwe = 1; e_mwe = 1; e_d = p % 256; e_m = p / 256; end
        'hF5, 'hFD: begin
          q = (o == 0) ? 65535 : num / o;
          e_dwe = 1; e_mwe = 1; e_d = q % 256; e_m = q / 256;
        end
        'hF3, 'hFB: begin e_dwe = 1; e_d = (o == 0) ? d : num % o; end
        default: e_bad = 1;
      endcase
    end
    t = tag_of(v, code, o);
    #2;
    check(t, "d_we", int'(d_we), e_dwe);
    check(t, "d_next", int'(d_next), e_d);
    check(t, "mhi_we", int'(mhi_we), e_mwe);
    if (e_mwe == 1) check(t, "mhi_next", int'(mhi_next), e_m);
    check(t, "bad_op", int'(bad_op), e_bad);
    @(posedge clk);
    #1;
    m_mhi = e_m;
    check(t, "mhi_q", int'(mhi_q), m_mhi);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0;
    d_in = '0; mem_opnd = '0; imm_opnd = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", "mhi_q in reset", int'(mhi_q), 0);
    check("R10", "d_we in reset", int'(d_we), 0);
    @(negedge clk); rst_n = 1'b1;

    run_op(1, 'h7B, 'h3C, 0, 0);          // R1
    run_op(1, 'h7B, 'hA5, 0, 0);          // R1
    run_op(1, 'hA1, 'h5E, 0, 0);          // R3
    run_op(1, 'h90, 'h00, 0, 0);          // R4 sees just-loaded value
    run_op(1, 'hA0, 'h77, 0, 0);          // R2
    run_op(1, 'h90, 'h12, 0, 0);          // R4
    run_op(1, 'hF4, 'hFF, 'hFF, 'h02);    // R5 memory form
    run_op(1, 'hFC, 'h10, 'hFF, 'h20);    // R5 immediate form
    run_op(1, 'hA1, 'h12, 0, 0);
    run_op(1, 'hF5, 'h34, 'h07, 'h99);    // R6 memory form
    run_op(1, 'hFD, 'hFF, 'h03, 'h01);    // R6 divide by one
    run_op(1, 'hF3, 'h55, 'h0A, 'h01);    // R7 memory form
    run_op(1, 'hFB, 'h55, 'h01, 'hFF);    // R7 immediate form
    run_op(1, 'hF5, 'h42, 'h00, 'h05);    // R8 zero memory divisor
    run_op(1, 'hF3, 'h42, 'h05, 'h00 + 8);
    run_op(1, 'hFB, 'h42, 'h05, 'h00);    // R8 zero modulo
    run_op(1, 'hFD, 'h42, 'h05, 'h00);    // R8 zero immediate divisor
    run_op(1, 'h86, 'h11, 1, 1);          // R9
    run_op(1, 'hF6, 'h11, 1, 1);          // R9
    run_op(1, 'h00, 'h11, 1, 1);          // R9
    run_op(0, 'hA0, 'h11, 1, 1);          // R10 idle with a code present

    for (int k = 0; k < 4000; k++) begin
      int codes[15] = '{'h7B, 'hA0, 'hA1, 'h90, 'hF4, 'hFC, 'hF5, 'hFD,
                        'hF3, 'hFB, 'h7A, 'hA2, 'hFF, 'h86, 'h91};
      int c, mo, io;
      c  = codes[$urandom_range(14, 0)];
      mo = ($urandom_range(7, 0) == 0) ? 0 : $urandom_range(255, 0);
      io = ($urandom_range(7, 0) == 0) ? 0 : $urandom_range(255, 0);
      run_op($urandom_range(9, 0) != 0, c, $urandom_range(255, 0), mo, io);
    end

    // reset clears a loaded high byte
    run_op(1, 'hA1, 'hC3, 0, 0);
    @(negedge clk); rst_n = 1'b0; op_valid = 1'b0;
    #2;
    m_mhi = 0;
    check("R10", "mhi_q after async reset", int'(mhi_q), 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule